// File: doc/BRIEF.md
# Wrapping Return-Address Stack

This block holds the return addresses of a small processor core. The core pushes its next program address when it runs a subroutine call, or when an interrupt forces a branch. It pops on any of its three return-type instructions: plain return, return with a literal, and return from interrupt. There are eight entries, each 13 bits wide. Software cannot reach the entries or the stack pointer. They sit outside both program space and data space.

The stack is a ring. It has no full or empty detection and no error flag. Once eight pushes are live, a further push replaces the oldest entry: the ninth push lands on the slot that the first push used, the tenth on the second slot, and so on. A pop on an empty stack also wraps, and it exposes whatever stale value sits in the slot it reaches. The entry at the top of the stack is always visible on a combinational output, so the core reads its return address in the same cycle that it strobes the pop.

Top module: `ret_addr_stack`

## Requirements
- R1: Reset clears the internal pointer to slot 0 and leaves the entry contents unchanged. After reset, `tos_o` shows the entry in slot DEPTH-1, which is the last slot written before reset when all eight slots were filled.
- R2: A push writes `push_addr_i` into the slot the pointer names and advances the pointer by one. From the next cycle `tos_o` equals the pushed value.
- R3: `tos_o` always shows the entry one slot below the pointer. A pop moves the pointer back by one, so after the edge `tos_o` shows the entry that was pushed before the popped one.
- R4: Up to eight pushes are returned in last-in, first-out order by the following pops.
- R5: Pushes wrap modulo 8 with no overflow indication. After nine pushes v1..v9, successive pops expose v9, v8, …, v2, and the ninth pop exposes v9 again.
- R6: A pop with the pointer at slot 0 wraps it to slot 7. `tos_o` then shows the entry in slot 6, and no flag or error is raised.
- R7: When push and pop are both asserted in one cycle, the push is carried out and the pop is ignored. The pointer advances, `tos_o` shows the pushed value, and the entries below it are untouched.
- R8: With neither strobe asserted, both the pointer and `tos_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the pointer only |
| push_i | input | 1 | Push strobe, from a call or an interrupt branch |
| push_addr_i | input | 13 | Return address to store on a push |
| pop_i | input | 1 | Pop strobe, from a return-type instruction |
| tos_o | output | 13 | Entry currently on top of the stack |

## Verification
A wrong pointer has no status pin to reveal it. It shows up only as a wrong `tos_o`. A pointer that steps incorrectly on a push is visible on the very next cycle, because `tos_o` must then equal the pushed address. A pointer that steps incorrectly on a pop is visible one cycle after that pop, as the wrong older entry. A slot that is written wrongly or clobbered stays hidden until enough pops bring it to the top. For this reason the bench pops every filled level back out, crosses the wrap boundary in both directions, and keeps a full reference image of all eight slots.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      RAS_IDLE = 2'd0,
      RAS_PUSH = 2'd1,
      RAS_POP  = 2'd2
   } ras_op_e;

   // a push outranks a pop raised in the same cycle
   function automatic ras_op_e ras_decode(input logic push, input logic pop);
      if (push)     return RAS_PUSH;
      else if (pop) return RAS_POP;
      else          return RAS_IDLE;
   endfunction

   function automatic bit ras_is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
   import ras_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ras_op_e       op,
   output logic          wr_en,
   output logic [PW-1:0] wr_idx,
   output logic [PW-1:0] rd_idx
);

   logic [PW-1:0] sp_q;

   // power-of-two depth lets the natural carry perform the wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else begin
         unique case (op)
            RAS_PUSH: sp_q <= sp_q + PW'(1);
            RAS_POP:  sp_q <= sp_q - PW'(1);
            default:  sp_q <= sp_q;
         endcase
      end
   end

   assign wr_en  = (op == RAS_PUSH);
   assign wr_idx = sp_q;
   assign rd_idx = sp_q - PW'(1);

endmodule

// File: rtl/ras_store.sv
module ras_store #(
   parameter int DEPTH     = 8,
   parameter int WIDTH     = 13,
   parameter bit RD_ONEHOT = 1'b0,
   localparam int PW       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PW-1:0]    wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [PW-1:0]    rd_idx,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] ent [DEPTH];

   // entries carry no reset: their contents are left undefined
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PW'(g))) ent[g] <= wr_data;
      end
   end

   if (RD_ONEHOT) begin : g_rd_andor
      always_comb begin
         rd_data = '0;
         for (int i = 0; i < DEPTH; i++) begin
            rd_data = rd_data | (ent[i] & {WIDTH{rd_idx == PW'(i)}});
         end
      end
   end else begin : g_rd_index
      assign rd_data = ent[rd_idx];
   end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int WIDTH     = 13,
   parameter bit RD_ONEHOT = 1'b0,
   localparam int PW       = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_addr_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] tos_o
);

   initial begin
      if (!ras_is_pow2(DEPTH)) $fatal(1, "ret_addr_stack: DEPTH must be a power of two, >= 2");
      if (WIDTH < 1)           $fatal(1, "ret_addr_stack: WIDTH must be at least 1");
   end

   ras_op_e       op;
   logic          wr_en;
   logic [PW-1:0] sp_q;
   logic [PW-1:0] rd_idx;

   assign op = ras_decode(push_i, pop_i);

   ras_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .wr_en  (wr_en),
      .wr_idx (sp_q),
      .rd_idx (rd_idx)
   );

   ras_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RD_ONEHOT(RD_ONEHOT)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (sp_q),
      .wr_data (push_addr_i),
      .rd_idx  (rd_idx),
      .rd_data (tos_o)
   );

endmodule

// File: rtl/ras_check.sv
module ras_check #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 13,
   localparam int PW   = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_i,
   input logic             pop_i,
   input logic [WIDTH-1:0] push_addr_i,
   input logic [WIDTH-1:0] tos_o,
   input logic [PW-1:0]    sp
);

   AST_PUSH_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> tos_o == $past(push_addr_i)); // R2

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> sp == PW'($past(sp) + PW'(1))); // R5

   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |=> sp == PW'($past(sp) - PW'(1))); // R3

   AST_BOTH_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && push_i) |=> (tos_o == $past(push_addr_i)) && (sp != PW'($past(sp) - PW'(1)))); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_i && !push_i) |=> $stable(sp) && $stable(tos_o)); // R8

endmodule

bind ret_addr_stack ras_check #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ras_check (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .push_addr_i (push_addr_i),
   .tos_o       (tos_o),
   .sp          (sp_q)
);

// File: tb/test_ret_addr_stack.sv
`timescale 1ns/1ps
module test_ret_addr_stack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push = 1'b0;
   logic        pop = 1'b0;
   logic [12:0] addr = '0;
   logic [12:0] tos;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [12:0] mdl [8];
   bit          mv  [8];
   int          mptr = 0;

   always #5 clk = ~clk;

   ret_addr_stack i_ret_addr_stack (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_addr_i(addr),
      .pop_i(pop), .tos_o(tos)
   );

   task automatic check(input string tag);
      int idx;
      idx = (mptr + 7) % 8;
      if (mv[idx]) begin
         n_chk++;
         if (tos !== mdl[idx]) begin
            n_bad++;
            $display("FAIL %s: tos actual %h expected %h", tag, tos, mdl[idx]);
         end
      end
   endtask

   task automatic step(input bit ps, input bit pp, input logic [12:0] d, input string tag);
      @(negedge clk);
      push = ps; pop = pp; addr = d;
      @(posedge clk);
      if (ps) begin
         mdl[mptr] = d; mv[mptr] = 1; mptr = (mptr + 1) % 8;
      end else if (pp) begin
         mptr = (mptr + 7) % 8;
      end
      #2;
      check(tag);
      @(negedge clk);
      push = 0; pop = 0;
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 0; push = 0; pop = 0;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      mptr = 0;
      #1;
      check(tag);
   endtask

   initial begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int i = 0; i < 8; i++) mv[i] = 0;
      do_reset("R1");

      // R2 fill, R4 drain in LIFO order
      for (int i = 0; i < 8; i++) step(1, 0, 13'h100 + 13'(i), "R2");
      for (int i = 0; i < 8; i++) step(0, 1, '0, "R4");
      // R6 underflow wraps to slot 7, top shows slot 6
      step(0, 1, '0, "R6");
      step(0, 1, '0, "R6");

      // R1 reset keeps contents: fill, reset, top = slot 7
      do_reset("R1");
      for (int i = 0; i < 8; i++) step(1, 0, 13'h0A0 + 13'(i), "R2");
      do_reset("R1");

      // R5 nine pushes then nine pops
      for (int i = 1; i <= 9; i++) step(1, 0, 13'h1F00 + 13'(i), "R5");
      for (int i = 0; i < 9; i++) step(0, 1, '0, "R5");

      // R7 both strobes, R8 idle
      do_reset("R1");
      step(1, 0, 13'h0111, "R2");
      step(1, 1, 13'h0222, "R7");
      step(0, 0, '0, "R8");
      step(0, 1, '0, "R7");
      step(0, 0, '0, "R8");

      // near-exhaustive sweep over operation mixes
      for (int i = 0; i < 3000; i++) begin
         bit ps, pp;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ps = lfsr[0]; pp = lfsr[1];
         step(ps, pp, lfsr[14:2], ps && pp ? "R7" : ps ? "R2" : pp ? "R3" : "R8");
      end

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule